// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This block lets data be read out of a 1024-word, 14-bit program memory. A software-visible 8-bit pointer register selects a word within a 256-word page. A request chooses the page. In current-page mode the page comes from the two upper bits of the running program counter. In last-page mode the page is forced to the top page of the four.

The word is fetched over a synchronous ROM port. Its low byte is returned with a one-cycle write strobe, for storage in a data-memory destination. The six remaining bits are zero-extended into a read-only high-byte register.

A read takes two clock cycles, each standing for one instruction cycle. In the first cycle the ROM is addressed. In the second cycle the fetched word is delivered together with a done pulse.

Requests use a valid/ready handshake. A request is taken only in a cycle where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the unit is idle. A requester may hold `req_valid` for as long as it needs to. While a read is in flight, back-pressure is applied by dropping `req_ready`, and requests presented then are not taken. The ROM port and the destination write carry no back-pressure: the ROM returns data one cycle after `rom_en`, and the destination must accept `dm_we` in the cycle it is shown.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the pointer and the high-byte register read 0, `req_ready` is 1, and `rom_en`, `dm_we` and `done` are 0.
- R2: A current-page request (`req_last_page`=0) drives `rom_addr` = {`pc_hi`, pointer}, with `pc_hi` in bits 9:8 and the pointer in bits 7:0.
- R3: A last-page request (`req_last_page`=1) drives `rom_addr` = {2'b11, pointer}, regardless of `pc_hi`.
- R4: `dm_wdata` equals bits 7:0 of the fetched word while `dm_we` is high, and `dm_we` is high for exactly one cycle per read.
- R5: After a read, the high-byte register reads {2'b00, fetched word bits 13:8}. Its bits 7:6 are always 0.
- R6: The high-byte register has no write path. It changes only at the end of a read's done cycle, and pointer writes or idle cycles leave it unchanged.
- R7: A pointer write (`ptr_we`=1) stores `ptr_wdata`, and the new value is visible on `ptr_rdata` in the next cycle.
- R8: Timing of a read: `rom_en` is high in the cycle after the request is taken. `done` and `dm_we` are then high together in the cycle after that, and only in that cycle.
- R9: While a read is in progress `req_ready` is 0, and any `req_valid` presented then starts no further ROM access.
- R10: The address is captured when the request is taken. A pointer write during a read does not alter the address of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_last_page | input | 1 | 1 = last page, 0 = current page |
| pc_hi | input | 2 | Upper program-counter bits for current-page mode |
| ptr_we | input | 1 | Pointer write enable |
| ptr_wdata | input | 8 | Pointer write data |
| ptr_rdata | output | 8 | Pointer read-back |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 10 | ROM word address |
| rom_data | input | 14 | ROM read data, valid the cycle after rom_en |
| dm_we | output | 1 | Destination data-memory write strobe |
| dm_wdata | output | 8 | Low byte of the fetched word |
| tblh_rdata | output | 8 | Read-only high-byte register |
| done | output | 1 | Read complete pulse |

## Verification
On every cycle, the assertions check the following. The handshake leads to `rom_en` and then `done` one cycle apart. `done` never lasts two cycles and always coincides with `dm_we`. `req_ready` stays low while the ROM is addressed. The page bits follow the requested mode. The top two high-byte bits stay zero, and the high-byte register holds whenever no read completes.

The data path itself can only be shown by the bench's scenarios against a modelled ROM. These cover the low byte reaching the destination, the high bits landing in the register, pointer read-back, an ignored request during a busy read, and an address that survives a pointer write in flight.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    TR_IDLE  = 2'd0,
    TR_FETCH = 2'd1,
    TR_WRITE = 2'd2
  } tr_state_e;
endpackage

// File: rtl/tblrd_ptr.sv
module tblrd_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (we) ptr_q <= wdata;
  end

  // R7: a write is visible the cycle after
  a_r7_ptr_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr_q == $past(wdata));
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ptr_q));
endmodule

// File: rtl/tblrd_addr.sv
module tblrd_addr #(
  parameter int ROM_AW = 10,
  parameter int PTR_W  = 8,
  localparam int PAGE_W = ROM_AW - PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              last_page,
  input  logic [PAGE_W-1:0] pc_hi,
  input  logic [PTR_W-1:0]  ptr,
  output logic [ROM_AW-1:0] addr_q
);
  logic [PAGE_W-1:0] page;

  generate
    if (PAGE_W > 0) begin : g_page
      assign page = last_page ? {PAGE_W{1'b1}} : pc_hi;
    end else begin : g_nopage
      assign page = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (load) addr_q <= {page, ptr};
  end

  // R3: last page forces all-ones page bits
  a_r3_last_page: assert property (@(posedge clk) disable iff (!rst_n)
    (load && last_page) |=> addr_q[ROM_AW-1 -: PAGE_W] == {PAGE_W{1'b1}});
  // R2: current page takes program counter bits
  a_r2_cur_page: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !last_page) |=> addr_q[ROM_AW-1 -: PAGE_W] == $past(pc_hi));
  // R10: address held until next load
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_q));
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq
  import tblrd_pkg::*;
#(
  parameter int ROM_DW = 14,
  parameter int DATA_W = 8,
  localparam int HI_W = ROM_DW - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  output logic              rom_en,
  input  logic [ROM_DW-1:0] rom_data,
  output logic              dm_we,
  output logic [DATA_W-1:0] dm_wdata,
  output logic              done,
  output logic [DATA_W-1:0] tblh_q
);
  tr_state_e state_q, state_d;

  assign req_ready = (state_q == TR_IDLE);
  assign accept    = req_valid && req_ready;
  assign rom_en    = (state_q == TR_FETCH);
  assign done      = (state_q == TR_WRITE);
  assign dm_we     = done;
  assign dm_wdata  = rom_data[DATA_W-1:0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TR_IDLE:  if (accept) state_d = TR_FETCH;
      TR_FETCH: state_d = TR_WRITE;
      TR_WRITE: state_d = TR_IDLE;
      default:  state_d = TR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TR_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tblh_q <= '0;
    else if (done) tblh_q <= {{(DATA_W-HI_W){1'b0}}, rom_data[ROM_DW-1:DATA_W]};
  end

  // R5: top bits of the high-byte register stay zero
  a_r5_tblh_top: assert property (@(posedge clk) disable iff (!rst_n)
    tblh_q[DATA_W-1:HI_W] == '0);
  // R6: high-byte register only changes after done
  a_r6_tblh_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(tblh_q));
  // R4: single-cycle write strobe
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> !dm_we);
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int ROM_AW = 10,
  parameter int ROM_DW = 14,
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ROM_AW - PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_last_page,
  input  logic [PAGE_W-1:0] pc_hi,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  output logic [PTR_W-1:0]  ptr_rdata,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [ROM_DW-1:0] rom_data,
  output logic              dm_we,
  output logic [DATA_W-1:0] dm_wdata,
  output logic [DATA_W-1:0] tblh_rdata,
  output logic              done
);
  logic accept;

  tblrd_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .we(ptr_we), .wdata(ptr_wdata), .ptr_q(ptr_rdata)
  );

  tblrd_addr #(.ROM_AW(ROM_AW), .PTR_W(PTR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .last_page(req_last_page),
    .pc_hi(pc_hi), .ptr(ptr_rdata), .addr_q(rom_addr)
  );

  tblrd_seq #(.ROM_DW(ROM_DW), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .rom_en(rom_en), .rom_data(rom_data), .dm_we(dm_we),
    .dm_wdata(dm_wdata), .done(done), .tblh_q(tblh_rdata)
  );

  // R8: request, then ROM access, then done
  a_r8_fetch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rom_en);
  a_r8_done_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> done && dm_we);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: no new request while the ROM is addressed
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_en || done) |-> !req_ready);
endmodule

// File: tb/sim_tblrd_unit.sv
module sim_tblrd_unit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_last_page = 1'b0;
  logic [1:0] pc_hi = 2'd0;
  logic       ptr_we = 1'b0;
  logic [7:0] ptr_wdata = 8'd0;
  logic [7:0] ptr_rdata;
  logic       rom_en;
  logic [9:0] rom_addr;
  logic [13:0] rom_data = 14'd0;
  logic       dm_we;
  logic [7:0] dm_wdata;
  logic [7:0] tblh_rdata;
  logic       done;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tblrd_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_last_page(req_last_page), .pc_hi(pc_hi), .ptr_we(ptr_we),
    .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata), .rom_en(rom_en),
    .rom_addr(rom_addr), .rom_data(rom_data), .dm_we(dm_we),
    .dm_wdata(dm_wdata), .tblh_rdata(tblh_rdata), .done(done)
  );

  function automatic logic [13:0] rom_fn(input logic [9:0] a);
    return (14'(a) * 14'd113) ^ 14'h2D3A ^ {a[3:0], 10'd0};
  endfunction

  always @(posedge clk) if (rom_en) rom_data <= rom_fn(rom_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ptr(input logic [7:0] v);
    ptr_we = 1'b1; ptr_wdata = v;
    @(negedge clk);
    ptr_we = 1'b0;
    chk(ptr_rdata == v, "R7", ptr_rdata, v);
  endtask

  // full read with checks at each cycle; inputs driven at negedge
  task automatic do_read(input bit last, input logic [1:0] pc, input logic [7:0] p);
    logic [9:0]  ea;
    logic [13:0] w;
    ea = last ? {2'b11, p} : {pc, p};
    w  = rom_fn(ea);
    req_valid = 1'b1; req_last_page = last; pc_hi = pc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rom_en == 1'b1, "R8", rom_en, 1);
    chk(rom_addr == ea, last ? "R3" : "R2", rom_addr, ea);
    chk(req_ready == 1'b0, "R9", req_ready, 0);
    @(negedge clk);
    chk(done && dm_we, "R8", {done, dm_we}, 3);
    chk(dm_wdata == w[7:0], "R4", dm_wdata, w[7:0]);
    @(negedge clk);
    chk(!done && !dm_we, "R4", {done, dm_we}, 0);
    chk(tblh_rdata == {2'b00, w[13:8]}, "R5", tblh_rdata, {2'b00, w[13:8]});
    chk(req_ready == 1'b1, "R8", req_ready, 1);
  endtask

  task automatic t_reset;
    chk(ptr_rdata == 8'd0, "R1", ptr_rdata, 0);
    chk(tblh_rdata == 8'd0, "R1", tblh_rdata, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(!rom_en && !dm_we && !done, "R1", {rom_en, dm_we, done}, 0);
  endtask

  task automatic t_current_page;
    write_ptr(8'h5C);
    do_read(1'b0, 2'd0, 8'h5C);
    do_read(1'b0, 2'd2, 8'h5C);
    write_ptr(8'hFF);
    do_read(1'b0, 2'd1, 8'hFF);
  endtask

  task automatic t_last_page;
    write_ptr(8'h03);
    do_read(1'b1, 2'd0, 8'h03);
    do_read(1'b1, 2'd1, 8'h03);
  endtask

  task automatic t_tblh_readonly;
    logic [7:0] keep;
    keep = tblh_rdata;
    write_ptr(8'hA7);
    repeat (3) @(negedge clk);
    chk(tblh_rdata == keep, "R6", tblh_rdata, keep);
    chk(tblh_rdata[7:6] == 2'b00, "R5", tblh_rdata[7:6], 0);
  endtask

  task automatic t_busy_ignored;
    logic [9:0]  ea;
    logic [13:0] w;
    write_ptr(8'h21);
    ea = {2'd3, 8'h21};
    w  = rom_fn(ea);
    req_valid = 1'b1; req_last_page = 1'b0; pc_hi = 2'd3;
    @(negedge clk);
    req_last_page = 1'b1; pc_hi = 2'd0; // request still held while busy
    chk(rom_addr == ea, "R9", rom_addr, ea);
    @(negedge clk);
    req_valid = 1'b0;
    chk(dm_wdata == w[7:0], "R9", dm_wdata, w[7:0]);
    @(negedge clk);
    chk(!rom_en, "R9", rom_en, 0);
    @(negedge clk);
    chk(!rom_en && !done, "R9", {rom_en, done}, 0);
  endtask

  task automatic t_ptr_write_in_flight;
    logic [9:0]  ea;
    logic [13:0] w;
    write_ptr(8'h90);
    ea = {2'd1, 8'h90};
    w  = rom_fn(ea);
    req_valid = 1'b1; req_last_page = 1'b0; pc_hi = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    ptr_we = 1'b1; ptr_wdata = 8'h0F;
    @(negedge clk);
    ptr_we = 1'b0;
    chk(dm_wdata == w[7:0], "R10", dm_wdata, w[7:0]);
    chk(ptr_rdata == 8'h0F, "R7", ptr_rdata, 8'h0F);
    @(negedge clk);
    chk(tblh_rdata == {2'b00, w[13:8]}, "R10", tblh_rdata, {2'b00, w[13:8]});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_current_page();
        t_last_page();
        t_tblh_readonly();
        t_busy_ignored();
        t_ptr_write_in_flight();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule